// File: doc/BRIEF.md
# SDRAM Activation-Timing Command Scheduler

This block sits between a client that issues single memory accesses and the command pins of a four-bank SDRAM. Each access names a bank, a row, a column and a direction. The block remembers which row is open in every bank. It turns the access at the head of the request port into the shortest legal command sequence:

- a READ or WRITE straight away when the row is already open;
- an ACTIVE and then the READ or WRITE when the bank is closed;
- a PRECHARGE, an ACTIVE and then the READ or WRITE when a different row is open in that bank.

Exactly one command leaves per clock. NOP fills every cycle in which a timing window is still closed.

The block enforces four windows, all given as clock counts at elaboration:

- the delay from an ACTIVE to a READ or WRITE on the same bank;
- the spacing between two ACTIVEs to the same bank;
- the spacing between ACTIVEs to any two banks;
- the recovery time from a PRECHARGE to the next ACTIVE on that bank.

Requests are served strictly in order. The request is accepted in the cycle in which its READ or WRITE is chosen. That command appears on the registered pins one clock later.

Top module: `sdr_act_sched`

## Requirements
- R1: After reset the pins show NOP, clock enable is high, ready is low with no request pending, and every bank is treated as closed.
- R2: Command codes on {cs_n, ras_n, cas_n, we_n} are: NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010. During NOP the bank and address pins are zero.
- R3: An ACTIVE carries the bank on ba_o and the row on addr_o[10:0]. A READ or WRITE carries the column on addr_o[7:0] with the upper address bits zero. A PRECHARGE carries the bank with an all-zero address, which closes that bank only.
- R4: A request to a closed bank issues ACTIVE at once when the windows allow. Its READ or WRITE then follows exactly T_RCD cycles after that ACTIVE.
- R5: A request whose row is already open in its bank issues its READ or WRITE, with no new ACTIVE, in the first cycle it is presented once T_RCD since the ACTIVE has elapsed.
- R6: A request for a different row in an open bank issues PRECHARGE first. The new ACTIVE then goes out in the first cycle that is both at least T_RP after the PRECHARGE and at least T_RC after the previous ACTIVE to that bank.
- R7: An ACTIVE to any bank is issued no earlier than T_RRD cycles after the previous ACTIVE to any bank, and in the first cycle that satisfies all windows.
- R8: req_ready_o is high only in the cycle in which the request's READ or WRITE is chosen. That command is on the pins in the following cycle.
- R9: With no valid request the block issues NOP.
- R10: Clock enable stays high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Access request present |
| req_ready_o | output | 1 | Request accepted this cycle |
| req_bank_i | input | BA_W | Target bank |
| req_row_i | input | ROW_W | Target row |
| req_col_i | input | COL_W | Target column |
| req_we_i | input | 1 | 1 = write, 0 = read |
| cke_o | output | 1 | Clock enable, held high |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ROW_W | Row or column address |

## Verification
The delicate case is a row miss in which the precharge recovery window and the same-bank ACTIVE spacing window close in the same cycle. The block must then release the ACTIVE exactly there, not one cycle late. The bench provokes this by sweeping the idle gap between two requests. With T_RCD=2, T_RP=3 and T_RC=7, a gap of one makes both windows expire together, a gap of zero leaves T_RC binding, and larger gaps leave T_RP binding. Each pin trace is compared slot by slot against the arithmetic maximum of the two limits. The same gap sweep moves the cross-bank ACTIVE between the case where T_RRD binds and the case where it has already elapsed.

// File: rtl/sdr_sched_pkg.sv
package sdr_sched_pkg;

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_ACT,
    CMD_RD,
    CMD_WR,
    CMD_PRE
  } cmd_e;

  // {cs_n, ras_n, cas_n, we_n}
  function automatic logic [3:0] cmd_pins(cmd_e c);
    case (c)
      CMD_ACT: cmd_pins = 4'b0011;
      CMD_RD:  cmd_pins = 4'b0101;
      CMD_WR:  cmd_pins = 4'b0100;
      CMD_PRE: cmd_pins = 4'b0010;
      default: cmd_pins = 4'b0111;
    endcase
  endfunction

endpackage

// File: rtl/sdr_dn_cnt.sv
module sdr_dn_cnt #(
  parameter int LIMIT = 3,
  parameter int W     = $clog2(LIMIT + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic zero_o
);

  logic [W-1:0] cnt_q;

  // load LIMIT-1 so the event LIMIT cycles after the load sees zero
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= W'(LIMIT - 1);
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/sdr_bank_state.sv
module sdr_bank_state #(
  parameter int ROW_W = 11,
  parameter int T_RCD = 3,
  parameter int T_RC  = 8,
  parameter int T_RP  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             act_i,
  input  logic             rw_i,
  input  logic             pre_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             rw_ok_o,
  output logic             act_ok_o
);

  logic open_q;
  logic [ROW_W-1:0] row_q;
  logic rcd_zero, rc_zero, rp_zero;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q <= 1'b0;
      row_q  <= '0;
    end else if (act_i) begin
      open_q <= 1'b1;
      row_q  <= row_i;
    end else if (pre_i) begin
      open_q <= 1'b0;
    end
  end

  sdr_dn_cnt #(.LIMIT(T_RCD)) u_rcd (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(act_i), .zero_o(rcd_zero));
  sdr_dn_cnt #(.LIMIT(T_RC)) u_rc (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(act_i), .zero_o(rc_zero));
  sdr_dn_cnt #(.LIMIT(T_RP)) u_rp (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(pre_i), .zero_o(rp_zero));

  assign open_o   = open_q;
  assign row_o    = row_q;
  assign rw_ok_o  = open_q & rcd_zero;
  assign act_ok_o = ~open_q & rc_zero & rp_zero;

  AST_RW_OPEN_RCD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rw_i |-> (open_q && rcd_zero)); // R4
  AST_PRE_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_i |-> open_q); // R6
  AST_ACT_WINDOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |-> (!open_q && rc_zero && rp_zero)); // R6
  AST_ACT_OPENS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |=> open_q); // R4

endmodule

// File: rtl/sdr_cmd_out.sv
module sdr_cmd_out
  import sdr_sched_pkg::*;
#(
  parameter int BA_W  = 2,
  parameter int ROW_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  cmd_e             cmd_i,
  input  logic [BA_W-1:0]  ba_i,
  input  logic [ROW_W-1:0] addr_i,
  output logic [3:0]       pins_o,
  output logic [BA_W-1:0]  ba_o,
  output logic [ROW_W-1:0] addr_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pins_o <= cmd_pins(CMD_NOP);
      ba_o   <= '0;
      addr_o <= '0;
    end else begin
      pins_o <= cmd_pins(cmd_i);
      ba_o   <= ba_i;
      addr_o <= addr_i;
    end
  end

endmodule

// File: rtl/sdr_act_sched.sv
module sdr_act_sched
  import sdr_sched_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BA_W      = $clog2(NUM_BANKS),
  parameter int ROW_W     = 11,
  parameter int COL_W     = 8,
  parameter int T_RCD     = 3,
  parameter int T_RRD     = 2,
  parameter int T_RC      = 8,
  parameter int T_RP      = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  output logic             req_ready_o,
  input  logic [BA_W-1:0]  req_bank_i,
  input  logic [ROW_W-1:0] req_row_i,
  input  logic [COL_W-1:0] req_col_i,
  input  logic             req_we_i,
  output logic             cke_o,
  output logic             cs_n_o,
  output logic             ras_n_o,
  output logic             cas_n_o,
  output logic             we_n_o,
  output logic [BA_W-1:0]  ba_o,
  output logic [ROW_W-1:0] addr_o
);

  logic [NUM_BANKS-1:0] open_w, rw_ok_w, act_ok_w;
  logic [NUM_BANKS-1:0] act_v, rw_v, pre_v;
  logic [ROW_W-1:0]     row_w [NUM_BANKS];
  logic                 rrd_zero;
  logic                 do_act, do_rw, do_pre;
  logic                 hit;
  cmd_e                 cmd_d;
  logic [BA_W-1:0]      ba_d;
  logic [ROW_W-1:0]     addr_d;
  logic [3:0]           pins_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign act_v[b] = do_act & (req_bank_i == BA_W'(b));
    assign rw_v[b]  = do_rw  & (req_bank_i == BA_W'(b));
    assign pre_v[b] = do_pre & (req_bank_i == BA_W'(b));

    sdr_bank_state #(
      .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RC(T_RC), .T_RP(T_RP)
    ) u_bank (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .act_i   (act_v[b]),
      .rw_i    (rw_v[b]),
      .pre_i   (pre_v[b]),
      .row_i   (req_row_i),
      .open_o  (open_w[b]),
      .row_o   (row_w[b]),
      .rw_ok_o (rw_ok_w[b]),
      .act_ok_o(act_ok_w[b])
    );
  end

  // cross-bank ACTIVE spacing
  sdr_dn_cnt #(.LIMIT(T_RRD)) u_rrd (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(do_act), .zero_o(rrd_zero));

  assign hit = open_w[req_bank_i] & (row_w[req_bank_i] == req_row_i);

  always_comb begin
    do_act = 1'b0;
    do_rw  = 1'b0;
    do_pre = 1'b0;
    if (req_valid_i) begin
      if (open_w[req_bank_i]) begin
        if (!hit)                        do_pre = 1'b1;
        else if (rw_ok_w[req_bank_i])    do_rw  = 1'b1;
      end else if (act_ok_w[req_bank_i] && rrd_zero) begin
        do_act = 1'b1;
      end
    end
  end

  always_comb begin
    cmd_d  = CMD_NOP;
    ba_d   = '0;
    addr_d = '0;
    if (do_act) begin
      cmd_d  = CMD_ACT;
      ba_d   = req_bank_i;
      addr_d = req_row_i;
    end else if (do_rw) begin
      cmd_d  = req_we_i ? CMD_WR : CMD_RD;
      ba_d   = req_bank_i;
      addr_d = ROW_W'(req_col_i);
    end else if (do_pre) begin
      cmd_d  = CMD_PRE;
      ba_d   = req_bank_i;
    end
  end

  sdr_cmd_out #(.BA_W(BA_W), .ROW_W(ROW_W)) u_out (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cmd_i (cmd_d),
    .ba_i  (ba_d),
    .addr_i(addr_d),
    .pins_o(pins_q),
    .ba_o  (ba_o),
    .addr_o(addr_o)
  );

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = pins_q;
  assign req_ready_o = do_rw;
  assign cke_o       = 1'b1;

  AST_READY_RW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |=> (pins_q == 4'b0101 || pins_q == 4'b0100)); // R8
  AST_ACT_ONLY_FROM_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pins_q == 4'b0011) |-> $past(req_valid_i)); // R9

  if (T_RRD > 1) begin : g_rrd_chk
    AST_NO_BACK2BACK_ACT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cmd_d == CMD_ACT) |-> (pins_q != 4'b0011)); // R7
  end

endmodule

// File: tb/tb_sdr_act_sched.sv
module tb_sdr_act_sched;

  localparam int D = 2, R = 4, C = 7, P = 3;
  localparam int ROW_W = 11, COL_W = 8, N = 24;
  localparam logic [3:0] P_NOP = 4'b0111, P_ACT = 4'b0011, P_RD = 4'b0101,
                         P_WR = 4'b0100, P_PRE = 4'b0010;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst_ni, valid, ready, we, cke, cs_n, ras_n, cas_n, we_n;
  logic [1:0]       bank, ba;
  logic [ROW_W-1:0] row, addr;
  logic [COL_W-1:0] col;

  sdr_act_sched #(.T_RCD(D), .T_RRD(R), .T_RC(C), .T_RP(P)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(valid), .req_ready_o(ready),
    .req_bank_i(bank), .req_row_i(row), .req_col_i(col), .req_we_i(we),
    .cke_o(cke), .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
    .ba_o(ba), .addr_o(addr));

  int checks = 0, errors = 0, cyc = 0;
  logic [3:0]       pl [N], ep [N];
  logic [1:0]       bl [N], eb [N];
  logic [ROW_W-1:0] al [N], ea [N];
  logic             rl [N], er [N];

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // compare trace slots lo..hi, report first mismatch
  task automatic cmp(input int lo, input int hi, input string req, input string tag);
    int bad = -1;
    for (int i = lo; i <= hi; i++)
      if (bad < 0 && (pl[i] != ep[i] || bl[i] != eb[i] || al[i] != ea[i])) bad = i;
    if (bad < 0) check(1'b1, req, tag, 0, 0);
    else check(1'b0, req, $sformatf("%s slot %0d {pins,ba,addr}", tag, bad),
               {pl[bad], bl[bad], al[bad]}, {ep[bad], eb[bad], ea[bad]});
  endtask

  task automatic put(input int t, input logic [3:0] p, input int b, input int a);
    ep[t] = p; eb[t] = 2'(b); ea[t] = ROW_W'(a);
  endtask

  task automatic run_scn(input int ba_a, input int ba_b, input bit same_row,
                         input bit wa, input bit wb, input int gap);
    logic [ROW_W-1:0] row_a = ROW_W'(ba_a * 37 + 5);
    logic [ROW_W-1:0] row_b = same_row ? row_a : (row_a ^ 11'h5a3);
    logic [COL_W-1:0] col_a = COL_W'(ba_a * 16 + 1);
    logic [COL_W-1:0] col_b = COL_W'(ba_b * 16 + 9);
    bit a_done = 0, b_done = 0, cke_ok = 1;
    int gl = gap, t0, act;
    string kind;
    @(negedge clk); rst_ni = 1'b0; valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    for (int j = 0; j < N; j++) begin
      if (!a_done) begin
        valid = 1; bank = 2'(ba_a); row = row_a; col = col_a; we = wa;
      end else if (gl > 0) begin
        valid = 0; gl--;
      end else if (!b_done) begin
        valid = 1; bank = 2'(ba_b); row = row_b; col = col_b; we = wb;
      end else valid = 0;
      #1;
      rl[j] = ready;
      if (valid && ready) begin
        if (!a_done) a_done = 1; else b_done = 1;
      end
      @(negedge clk);
      pl[j] = {cs_n, ras_n, cas_n, we_n}; bl[j] = ba; al[j] = addr;
      if (cke !== 1'b1) cke_ok = 0;
    end
    valid = 0;
    for (int i = 0; i < N; i++) begin put(i, P_NOP, 0, 0); er[i] = 0; end
    put(0, P_ACT, ba_a, row_a);
    put(D, wa ? P_WR : P_RD, ba_a, col_a); er[D] = 1;
    t0 = D + 1 + gap;
    if (ba_b == ba_a && same_row) begin
      kind = "R5";
      put(t0, wb ? P_WR : P_RD, ba_b, col_b); er[t0] = 1;
    end else if (ba_b == ba_a) begin
      kind = "R6";
      put(t0, P_PRE, ba_b, 0);
      act = (t0 + P > C) ? t0 + P : C;
      put(act, P_ACT, ba_b, row_b);
      put(act + D, wb ? P_WR : P_RD, ba_b, col_b); er[act + D] = 1;
    end else begin
      kind = "R7";
      act = (t0 > R) ? t0 : R;
      put(act, P_ACT, ba_b, row_b);
      put(act + D, wb ? P_WR : P_RD, ba_b, col_b); er[act + D] = 1;
    end
    cmp(0, D, "R4,R2,R3", "first access");
    if (gap > 0) cmp(D + 1, D + gap, "R9", "idle gap");
    cmp(D + 1, N - 1, kind, "second access");
    begin
      logic [N-1:0] ra, re;
      for (int i = 0; i < N; i++) begin ra[i] = rl[i]; re[i] = er[i]; end
      check(ra == re, "R8", "ready pattern", int'(ra), int'(re));
    end
    check(cke_ok, "R10", "cke high", int'(cke_ok), 1);
  endtask

  initial begin
    rst_ni = 1'b0; valid = 0; bank = 0; row = 0; col = 0; we = 0;
    repeat (3) @(negedge clk);
    // reset state
    check({cs_n, ras_n, cas_n, we_n} == P_NOP, "R1", "reset pins",
          {cs_n, ras_n, cas_n, we_n}, P_NOP);
    check(cke === 1'b1 && ready === 1'b0, "R1", "reset cke/ready",
          {cke, ready}, 2'b10);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    check({cs_n, ras_n, cas_n, we_n, ba, addr} == {P_NOP, 2'b00, 11'h0}, "R9",
          "idle after reset", {cs_n, ras_n, cas_n, we_n, ba, addr}, {P_NOP, 13'h0});
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int s = 0; s < 2; s++)
          for (int w = 0; w < 4; w++)
            for (int g = 0; g < 4; g++)
              run_scn(a, b, s[0], w[0], w[1], g);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule